// File: doc/BRIEF.md
# Multi-domain shutdown reset sequencer

This control-domain state machine starts, pauses and stops a DMA engine whose source and destination data paths sit in other clock domains. A request to run raises the engine-wide enable and the per-side enables. A pause request only gates the per-side enables. When that pause is lifted, both sides carry on from where they stopped, with no reset.

When the run request is withdrawn, the sequencer does not flush the data paths. It first lets both sides finish their outstanding transactions, which the per-side idle inputs report. It then puts both data domains into reset and holds that reset long enough for the slowest domain to see a minimum number of its own clock edges. After that it releases the sink side first and the source side some cycles later. The engine-wide enable stays low until the whole sequence is over. Power-up runs the same reset sequence.

All clock-domain timing is expressed in control-domain cycles. Each idle input passes through a two-flop synchroniser.

Top module: `dma_shutdown_seq`

## Requirements
- R1: While `rst` is high, both `src_reset` and `dst_reset` are 1 and every enable output is 0. After `rst` falls, the block runs the reset release sequence and then rests idle with all five outputs at 0.
- R2: When idle, a high `enable_req` at a clock edge sets `core_enable`, `src_enable` and `dst_enable` to 1 after that edge.
- R3: While running, a high `pause_req` drives `src_enable` and `dst_enable` to 0. During the pause `core_enable` stays 1 and no reset is raised. When `pause_req` falls, both enables return to 1, again with no reset.
- R4: When `enable_req` is 0 while running, `core_enable` falls to 0 after the next edge. Both side enables stay 1, and no reset is raised until both `src_idle` and `dst_idle` are high. Each idle input is delayed by a 2-flop synchroniser, so the resets rise after the third edge that samples both high.
- R5: Once the resets are raised, both stay asserted for exactly SLOW_RATIO*MIN_SLOW_CYCLES control cycles (12 with the defaults). While a side's reset is asserted, that side's enable is 0.
- R6: `dst_reset` is released first. `src_reset` is released RELEASE_GAP cycles later (3 with the defaults). `dst_reset` is never 1 while `src_reset` is 0.
- R7: Changes on `enable_req` during draining or reset are ignored. `core_enable` stays 0 until the sequence has returned to idle. If `enable_req` is then high, `core_enable` rises two cycles after `src_reset` falls.
- R8: All resets are active high: a value of 1 on `src_reset` or `dst_reset` means that domain is held in reset.
- R9: While draining, `pause_req` has no effect: both side enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_req | input | 1 | Request to run the engine |
| pause_req | input | 1 | Request to gate the data domains |
| src_idle | input | 1 | Source side has no outstanding transaction (asynchronous) |
| dst_idle | input | 1 | Destination side has no outstanding transaction (asynchronous) |
| core_enable | output | 1 | Engine-wide enable for the other blocks |
| src_enable | output | 1 | Source data domain enable |
| dst_enable | output | 1 | Destination data domain enable |
| src_reset | output | 1 | Source data domain reset, active high |
| dst_reset | output | 1 | Destination data domain reset, active high |

## Verification
The bench uses the default parameters: a slowest-domain ratio of 3 with a minimum of 4 slow cycles, so the reset hold is 12 control cycles, and a release gap of 3. These values are small enough that the bench can count the exact length of the hold and the exact cycle of each release, both after power-up and after a drained shutdown. They also leave room to toggle the run request in the middle of draining and reset, and to apply pause while running and while draining.

// File: rtl/dma_shutdown_seq.sv
module dma_shutdown_seq #(
  parameter int SLOW_RATIO      = 3,
  parameter int MIN_SLOW_CYCLES = 4,
  parameter int RELEASE_GAP     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_req,
  input  logic pause_req,
  input  logic src_idle,
  input  logic dst_idle,
  output logic core_enable,
  output logic src_enable,
  output logic dst_enable,
  output logic src_reset,
  output logic dst_reset
);

  localparam int HOLD = SLOW_RATIO * MIN_SLOW_CYCLES;
  localparam int MAXC = (HOLD > RELEASE_GAP) ? HOLD : RELEASE_GAP;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RUN, S_DRAIN, S_RST, S_REL_DST, S_REL_SRC
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [1:0]    src_sync, dst_sync;

  wire src_idle_s = src_sync[1];
  wire dst_idle_s = dst_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_RST;
      cnt      <= CW'(HOLD - 1);
      src_sync <= '0;
      dst_sync <= '0;
    end else begin
      src_sync <= {src_sync[0], src_idle};
      dst_sync <= {dst_sync[0], dst_idle};
      case (state)
        S_IDLE:    if (enable_req) state <= S_RUN;
        S_RUN:     if (!enable_req) state <= S_DRAIN;
        S_DRAIN:   if (src_idle_s && dst_idle_s) begin
                     state <= S_RST;
                     cnt   <= CW'(HOLD - 1);
                   end
        S_RST:     if (cnt == '0) begin
                     state <= S_REL_DST;
                     cnt   <= CW'(RELEASE_GAP - 1);
                   end else cnt <= cnt - 1'b1;
        S_REL_DST: if (cnt == '0) state <= S_REL_SRC;
                   else cnt <= cnt - 1'b1;
        S_REL_SRC: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign core_enable = (state == S_RUN);
  assign src_enable  = ((state == S_RUN) && !pause_req) || (state == S_DRAIN);
  assign dst_enable  = src_enable;
  assign dst_reset   = (state == S_RST);
  assign src_reset   = (state == S_RST) || (state == S_REL_DST);

  logic [CW:0] held;
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (!dst_reset) held <= '0;
    else if (held < (CW+1)'(HOLD)) held <= held + 1'b1;
  end

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(dst_reset) |-> (held >= (CW+1)'(HOLD))); // R5
  AST_DST_INSIDE_SRC: assert property (@(posedge clk) disable iff (rst)
    dst_reset |-> src_reset); // R6
  AST_SRC_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(src_reset) |-> (!dst_reset && $past(!dst_reset))); // R6
  AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(dst_reset) |-> $past(src_idle_s && dst_idle_s)); // R4
  AST_RESET_GATES_ENABLE: assert property (@(posedge clk) disable iff (rst)
    src_reset |-> (!src_enable && !dst_enable && !core_enable)); // R5
  AST_CORE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(core_enable) |-> $past(state == S_IDLE)); // R7
  AST_PAUSE_NO_RESET: assert property (@(posedge clk) disable iff (rst)
    (state == S_RUN) |=> !src_reset); // R3

endmodule

// File: tb/dma_shutdown_seq_tb.sv
module dma_shutdown_seq_tb_top;
  localparam int HOLD = 12;
  localparam int GAP  = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic enable_req = 0, pause_req = 0, src_idle = 0, dst_idle = 0;
  logic core_enable, src_enable, dst_enable, src_reset, dst_reset;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_shutdown_seq dut_i (
    .clk(clk), .rst(rst), .enable_req(enable_req), .pause_req(pause_req),
    .src_idle(src_idle), .dst_idle(dst_idle), .core_enable(core_enable),
    .src_enable(src_enable), .dst_enable(dst_enable),
    .src_reset(src_reset), .dst_reset(dst_reset));

  wire [4:0] outs = {core_enable, src_enable, dst_enable, src_reset, dst_reset};

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // {enable_req, pause_req, core, src_en, dst_en, src_rst, dst_rst}
  localparam logic [6:0] VEC [8] = '{
    7'b00_00000,  // R2 idle stays idle
    7'b10_11100,  // R2 start
    7'b11_10000,  // R3 pause
    7'b11_10000,  // R3 pause held
    7'b10_11100,  // R3 resume without reset
    7'b10_11100,  // R3 running
    7'b01_01100,  // R9 drain, pause ignored
    7'b00_01100   // R4 drain waits on idle
  };

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    int core_seen;
    repeat (3) step();
    chk("R1 R8 outputs in reset", outs, 5'b00011);
    rst = 1'b0;
    k = 0;
    while (dst_reset && k < 100) begin step(); k++; end
    chk("R1 R5 power-up hold", k, HOLD);
    chk("R6 src still in reset", src_reset, 1);
    k = 0;
    while (src_reset && k < 100) begin step(); k++; end
    chk("R6 release gap", k, GAP);
    step();
    chk("R1 idle after sequence", outs, 5'b00000);

    for (int i = 0; i < 8; i++) begin
      enable_req = VEC[i][6];
      pause_req  = VEC[i][5];
      step();
      chk($sformatf("R2 R3 R9 vector %0d", i), outs, VEC[i][4:0]);
    end
    pause_req = 1'b0;

    src_idle = 1'b1;
    repeat (4) step();
    chk("R4 one side idle only", outs, 5'b01100);
    enable_req = 1'b1; step();
    chk("R7 enable ignored in drain", outs, 5'b01100);
    enable_req = 1'b0; step();
    dst_idle = 1'b1;
    step(); step();
    chk("R4 sync delay", dst_reset, 0);
    step();
    chk("R4 R5 reset raised", outs, 5'b00011);
    enable_req = 1'b1;
    k = 0; core_seen = 0;
    while (dst_reset && k < 100) begin
      step(); k++;
      if (core_enable) core_seen = 1;
      if (k == 3) enable_req = 1'b0;
      if (k == 5) enable_req = 1'b1;
    end
    chk("R5 shutdown hold", k, HOLD);
    chk("R6 dst first", src_reset, 1);
    k = 0;
    while (src_reset && k < 100) begin
      step(); k++;
      if (core_enable) core_seen = 1;
    end
    chk("R6 shutdown gap", k, GAP);
    chk("R7 no early core enable", core_seen, 0);
    step();
    chk("R7 idle before restart", core_enable, 0);
    step();
    chk("R7 restart", outs, 5'b11100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule